// File: doc/BRIEF.md
# Snapshot Median-of-Five Sequencer

This block reads a 5-bit receiver gain estimate from an equaliser status word five times in a row and reports the median of the five readings. The equaliser has a snapshot handshake. The sequencer waits until the equaliser's done flag is low, raises a snapshot-start line, and waits for done to rise. It then takes the gain from the status word and drops start. This sequence repeats until five samples have been gathered.

Each wait is limited to a fixed number of checks, one check per clock. If a wait runs out, the request is not abandoned. The sample is taken from whatever the status word holds at that moment, and a sticky timeout flag records the event. Once all five samples are stored, a fixed compare-exchange network sorts them. The third-smallest value is then registered as the result, together with a single-cycle valid strobe.

Top module: `snap_median_seq`

## Requirements
- R1: After reset, busy, snapStart, resultValid, timeoutFlag and median are all zero.
- R2: A request is accepted only when reqStart is high while busy is low. Each accepted request produces exactly five snapStart pulses before its result.
- R3: Before each snapshot, snapStart stays low until snapDone is seen low. If snapDone stays high, snapStart rises after exactly WAIT_LIMIT low cycles, counted from the cycle busy rises.
- R4: While waiting for snapDone to rise, snapStart stays high until snapDone is seen high. If snapDone never rises, snapStart stays high for exactly WAIT_LIMIT cycles.
- R5: The captured gain is statusWord[28:24], sampled on the clock edge where snapDone is seen high, or on the edge where the wait expires. All other statusWord bits have no effect on the result.
- R6: After each capture, snapStart drops and stays low for at least one cycle.
- R7: median equals the element at index 2 of the five captured gains sorted in ascending order, duplicates included.
- R8: resultValid is high for exactly one cycle per request, and median holds its value afterwards.
- R9: If either wait expires, timeoutFlag is set and stays set. The request still finishes with five captures, and the flag is cleared only when the next request is accepted.
- R10: A reqStart pulse while busy is high is ignored: there are no extra snapshots, and busy is low in the cycle after resultValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Request a median measurement |
| snapDone | input | 1 | Snapshot done flag from the equaliser |
| statusWord | input | 32 | Equaliser status word; gain in bits 28:24 |
| snapStart | output | 1 | Snapshot start request to the equaliser |
| busy | output | 1 | A measurement is in progress |
| resultValid | output | 1 | One-cycle strobe: median is new |
| median | output | 5 | Median of the five captured gains |
| timeoutFlag | output | 1 | Sticky: a wait expired during this request |

## Verification
The checker assumes that reqStart pulses only matter when the block is idle. It also assumes that snapDone may take any value at any time, including staying stuck high or low. It does not assume that the equaliser follows the handshake. The bench's equaliser model covers three cases: a well-behaved responder with varied rise and release delays, a done flag stuck high, and a done flag that never responds. It fills every statusWord bit outside the gain field with random data. Sample sets include random values, all-equal values, ascending and descending orders, and the extremes 0 and 31.

// File: rtl/snap_med_pkg.sv
package snap_med_pkg;
  localparam int SNAP_COUNT = 5;
  localparam int SLOT_W = $clog2(SNAP_COUNT);

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_LOW,
    S_WAIT_HIGH,
    S_RELEASE,
    S_SORT
  } snapState_t;

  typedef struct packed {
    logic              capture;
    logic [SLOT_W-1:0] slot;
    logic              loadResult;
    logic              setTimeout;
    logic              clearTimeout;
  } snapStrobe_t;
endpackage

// File: rtl/snap_med_ctrl.sv
module snap_med_ctrl
  import snap_med_pkg::*;
#(
  parameter int WAIT_LIMIT = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqStart,
  input  logic        snapDone,
  output logic        snapStart,
  output logic        busy,
  output snapStrobe_t strobe
);
  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_CHECK = CNT_W'(WAIT_LIMIT - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SNAP_COUNT - 1);

  snapState_t state;
  logic [CNT_W-1:0] waitCnt;
  logic [SLOT_W-1:0] slot;
  logic expired;

  assign expired = (waitCnt == LAST_CHECK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
      slot    <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqStart) begin
          state   <= S_WAIT_LOW;
          waitCnt <= '0;
          slot    <= '0;
        end
        S_WAIT_LOW: begin
          if (!snapDone || expired) begin
            state   <= S_WAIT_HIGH;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_WAIT_HIGH: begin
          if (snapDone || expired) begin
            state   <= S_RELEASE;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_RELEASE: begin
          if (slot == LAST_SLOT) begin
            state <= S_SORT;
          end else begin
            slot  <= slot + 1'b1;
            state <= S_WAIT_LOW;
          end
        end
        S_SORT:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clearTimeout = (state == S_IDLE) && reqStart;
    strobe.setTimeout   = expired &&
                          (((state == S_WAIT_LOW) && snapDone) ||
                           ((state == S_WAIT_HIGH) && !snapDone));
    strobe.capture      = (state == S_WAIT_HIGH) && (snapDone || expired);
    strobe.slot         = slot;
    strobe.loadResult   = (state == S_SORT);
  end

  assign snapStart = (state == S_WAIT_HIGH);
  assign busy      = (state != S_IDLE);
endmodule

// File: rtl/snap_med_data.sv
module snap_med_data
  import snap_med_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int GAIN_LSB = 24,
  parameter int GAIN_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  snapStrobe_t       strobe,
  input  logic [WORD_W-1:0] statusWord,
  output logic [GAIN_W-1:0] median,
  output logic              resultValid,
  output logic              timeoutFlag
);
  localparam int NUM_CX = 9;
  localparam int MID = SNAP_COUNT / 2;
  localparam int LO_IDX[NUM_CX] = '{0, 3, 2, 2, 1, 0, 0, 1, 1};
  localparam int HI_IDX[NUM_CX] = '{1, 4, 4, 3, 4, 3, 2, 3, 2};

  logic [GAIN_W-1:0] samples [SNAP_COUNT];
  logic [GAIN_W-1:0] net [NUM_CX+1][SNAP_COUNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SNAP_COUNT; i++) samples[i] <= '0;
    end else if (strobe.capture) begin
      samples[strobe.slot] <= statusWord[GAIN_LSB +: GAIN_W];
    end
  end

  for (genvar j = 0; j < SNAP_COUNT; j++) begin : g_in
    assign net[0][j] = samples[j];
  end

  for (genvar k = 0; k < NUM_CX; k++) begin : g_stage
    logic swapNeeded;
    assign swapNeeded = net[k][LO_IDX[k]] > net[k][HI_IDX[k]];
    for (genvar j = 0; j < SNAP_COUNT; j++) begin : g_lane
      if (j == LO_IDX[k]) begin : g_lo
        assign net[k+1][j] = swapNeeded ? net[k][HI_IDX[k]] : net[k][j];
      end else if (j == HI_IDX[k]) begin : g_hi
        assign net[k+1][j] = swapNeeded ? net[k][LO_IDX[k]] : net[k][j];
      end else begin : g_pass
        assign net[k+1][j] = net[k][j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      median      <= '0;
      resultValid <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      resultValid <= strobe.loadResult;
      if (strobe.loadResult) median <= net[NUM_CX][MID];
      if (strobe.clearTimeout)    timeoutFlag <= 1'b0;
      else if (strobe.setTimeout) timeoutFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/snap_median_seq.sv
module snap_median_seq
  import snap_med_pkg::*;
#(
  parameter int WAIT_LIMIT = 100,
  parameter int WORD_W     = 32,
  parameter int GAIN_LSB   = 24,
  parameter int GAIN_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              snapDone,
  input  logic [WORD_W-1:0] statusWord,
  output logic              snapStart,
  output logic              busy,
  output logic              resultValid,
  output logic [GAIN_W-1:0] median,
  output logic              timeoutFlag
);
  snapStrobe_t strobe;

  snap_med_ctrl #(.WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .snapDone(snapDone),
    .snapStart(snapStart), .busy(busy), .strobe(strobe)
  );

  snap_med_data #(.WORD_W(WORD_W), .GAIN_LSB(GAIN_LSB), .GAIN_W(GAIN_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusWord(statusWord),
    .median(median), .resultValid(resultValid), .timeoutFlag(timeoutFlag)
  );
endmodule

// File: rtl/snap_median_chk.sv
module snap_median_chk (
  input logic clk,
  input logic rstN,
  input logic reqStart,
  input logic snapStart,
  input logic busy,
  input logic resultValid,
  input logic timeoutFlag
);
  logic prevStart;
  logic [3:0] riseCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStart <= 1'b0;
      riseCount <= '0;
    end else begin
      prevStart <= snapStart;
      if (reqStart && !busy)          riseCount <= '0;
      else if (snapStart && !prevStart) riseCount <= riseCount + 1'b1;
    end
  end

  // R2: five snapshot pulses before each result
  a_r2_five_snaps: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (riseCount == 4'd5));

  a_r2_start_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    snapStart |-> busy);

  // R6: start stays low for at least one cycle after a capture
  a_r6_release_gap: assert property (@(posedge clk) disable iff (!rstN)
    (prevStart && !snapStart) |=> !snapStart);

  // R8: result strobe is a single cycle
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R9: flag stays set until a new request is accepted
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !(reqStart && !busy)) |=> timeoutFlag);

  // R10: idle stays idle without a request
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqStart) |=> !busy);
endmodule

bind snap_median_seq snap_median_chk u_chk (
  .clk(clk), .rstN(rstN), .reqStart(reqStart), .snapStart(snapStart),
  .busy(busy), .resultValid(resultValid), .timeoutFlag(timeoutFlag)
);

// File: tb/tb_snap_median_seq.sv
module tb_snap_median_seq;
  localparam int WAIT_LIMIT = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0;
  logic snapDone = 1'b0;
  logic [31:0] statusWord = '0;
  logic snapStart, busy, resultValid, timeoutFlag;
  logic [4:0] median;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // equaliser model controls, written only by the stimulus task
  int modelMode = 0;     // 0 normal, 1 done stuck high, 2 done never rises
  int respDelay = 0;
  int dropDelay = 0;
  logic [4:0] samp [5];
  int fallBase = 0;

  int falls = 0;
  int dly = 0;
  logic prevStart = 1'b0;

  always #5 clk = ~clk;

  snap_median_seq #(.WAIT_LIMIT(WAIT_LIMIT)) dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .snapDone(snapDone),
    .statusWord(statusWord), .snapStart(snapStart), .busy(busy),
    .resultValid(resultValid), .median(median), .timeoutFlag(timeoutFlag)
  );

  // equaliser model, acting on falling edges
  always @(negedge clk) begin
    int idx;
    if (prevStart && !snapStart) falls = falls + 1;
    prevStart = snapStart;
    idx = falls - fallBase;
    if (idx > 4) idx = 4;
    if (idx < 0) idx = 0;
    statusWord <= {$urandom_range(7, 0) == 0 ? 3'b111 : 3'($urandom), samp[idx], 24'($urandom)};
    case (modelMode)
      1: snapDone <= 1'b1;
      2: snapDone <= 1'b0;
      default: begin
        if (snapStart && !snapDone) begin
          if (dly >= respDelay) begin snapDone <= 1'b1; dly = 0; end
          else dly = dly + 1;
        end else if (!snapStart && snapDone) begin
          if (dly >= dropDelay) begin snapDone <= 1'b0; dly = 0; end
          else dly = dly + 1;
        end else dly = 0;
      end
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expMedian();
    for (int c = 0; c < 5; c++) begin
      int less = 0;
      int eq = 0;
      for (int o = 0; o < 5; o++) begin
        if (samp[o] < samp[c]) less++;
        else if (samp[o] == samp[c]) eq++;
      end
      if (less <= 2 && less + eq >= 3) return int'(samp[c]);
    end
    return -1;
  endfunction

  task automatic runOne(input int mode, input int rDly, input int dDly, input bit pokeBusy);
    int rises = 0;
    int highLen = 0;
    int maxHigh = 0;
    int preLow = 0;
    bit first = 0;
    int n = 0;
    int expM;
    logic [4:0] held;
    modelMode = mode;
    respDelay = rDly;
    dropDelay = dDly;
    expM = expMedian();
    @(negedge clk);
    fallBase = falls;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    while (!resultValid && n < 5000) begin
      if (snapStart) begin
        first = 1;
        highLen++;
        if (highLen == 1) rises++;
        if (highLen > maxHigh) maxHigh = highLen;
      end else begin
        highLen = 0;
        if (!first && busy) preLow++;
      end
      reqStart = (pokeBusy && n == 7);
      @(negedge clk);
      n++;
    end
    reqStart = 1'b0;
    check(resultValid, "R8 result arrives", int'(resultValid), 1);
    check(median == 5'(expM), "R7 median value", int'(median), expM);
    check(rises == 5, "R2 five snapshots", rises, 5);
    check(timeoutFlag == (mode != 0), "R9 timeout flag", int'(timeoutFlag), int'(mode != 0));
    if (mode == 1) check(preLow == WAIT_LIMIT, "R3 wait-low limit", preLow, WAIT_LIMIT);
    if (mode == 2) check(maxHigh == WAIT_LIMIT, "R4 wait-high limit", maxHigh, WAIT_LIMIT);
    held = median;
    @(negedge clk);
    check(!resultValid, "R8 single-cycle valid", int'(resultValid), 0);
    check(median == held, "R8 median held", int'(median), int'(held));
    if (pokeBusy) check(!busy, "R10 busy request ignored", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !snapStart && !resultValid && !timeoutFlag && median == 0,
          "R1 reset state", int'({busy, snapStart, resultValid, timeoutFlag}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !snapStart, "R1 idle after reset", int'(busy), 0);

    // R7 corner sets
    samp = '{5'd7, 5'd7, 5'd7, 5'd7, 5'd7};      runOne(0, 0, 0, 0);
    samp = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4};      runOne(0, 1, 2, 0);
    samp = '{5'd31, 5'd20, 5'd10, 5'd5, 5'd0};   runOne(0, 3, 0, 0);
    samp = '{5'd31, 5'd31, 5'd0, 5'd0, 5'd31};   runOne(0, 2, 1, 0);
    samp = '{5'd0, 5'd0, 5'd31, 5'd0, 5'd31};    runOne(0, 0, 3, 0);
    // R9: done stuck high, then done never rises (R3, R4, R5 capture on expiry)
    samp = '{5'd9, 5'd2, 5'd30, 5'd14, 5'd14};   runOne(1, 0, 0, 0);
    samp = '{5'd4, 5'd25, 5'd1, 5'd18, 5'd6};    runOne(2, 0, 0, 0);
    // R9: flag clears on the next accepted request; R10 busy poke
    samp = '{5'd3, 5'd8, 5'd8, 5'd1, 5'd12};     runOne(0, 1, 1, 1);
    // R5/R7 random sweep with random non-gain bits
    for (int t = 0; t < 300; t++) begin
      for (int s = 0; s < 5; s++) samp[s] = 5'($urandom);
      runOne(0, t % 4, (t / 4) % 3, (t % 37) == 0);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule